// File: doc/BRIEF.md
# Shadowed SRAM store controller

This block is the control core of a nonvolatile SRAM that copies its array into shadow nonvolatile cells when power fails. Several such memories share one active-low request line. Each device can pull the line down but cannot drive it high, because an external pull-up supplies the high level. Any device that pulls the line low, whether after a local power-fail detection or because a store was requested, makes every device on the line enter a store cycle.

A device programs its shadow cells only if its SRAM has been written since the last store or recall. While it programs, it holds the shared line low. A device with nothing new to save does not program and does not drive the line. In both cases the device keeps reads and writes locked until the shared line reads high again. A low-voltage flag from the storage-capacitor comparator blocks SRAM writes and store commands that come from outside. The nonvolatile programming time is modelled as a parameterised count of cycles.

Top module: `nvsram_store_ctrl`

## Requirements
- R1: After synchronous reset, `req_pull_o`, `wr_en_o` and `store_done_o` are 0 and `access_en_o` is 1.
- R2: In idle, `wr_req_i` high with `vlow_i` low produces `wr_en_o` high one cycle later. With `vlow_i` high, `wr_en_o` stays 0.
- R3: While `vlow_i` is 1, `ext_store_i` is ignored. No pull-down occurs, `access_en_o` stays 1, and the dirty state is kept for a later store.
- R4: A request that arrives while the SRAM is dirty raises `req_pull_o` in the next cycle and holds it for exactly STORE_CYCLES cycles. `store_done_o` pulses for one cycle in the cycle where `req_pull_o` falls.
- R5: A request that arrives while the SRAM is clean causes no pull-down and no `store_done_o`. `access_en_o` drops in the next cycle.
- R6: A low level on `req_n_i` passes through a two-flop synchronizer, so it acts as a request on the third clock edge after the level is applied.
- R7: After a store or a clean request, `access_en_o` stays 0 until the shared line is seen high while the block is not pulling it. It returns to 1 on the third edge after the line rises.
- R8: `pfail_i` starts a store even when `vlow_i` is 1. While `pfail_i` stays high the pull-down is held after programming has ended.
- R9: Completion of a store, or a `recall_done_i` pulse, makes the SRAM clean, so the next request performs no programming.
- R10: While `access_en_o` is 0, `wr_req_i` produces no `wr_en_o` and leaves the SRAM clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n_i | input | 1 | Level of the shared active-low store-request line (asynchronous) |
| pfail_i | input | 1 | Local power-loss detect |
| vlow_i | input | 1 | Storage capacitor below switch threshold |
| ext_store_i | input | 1 | Externally initiated store command |
| wr_req_i | input | 1 | SRAM write request |
| recall_done_i | input | 1 | Pulse marking the end of a recall |
| req_pull_o | output | 1 | Output-enable of the open-drain pull-down on the shared line |
| wr_en_o | output | 1 | Gated SRAM write strobe |
| access_en_o | output | 1 | Reads and writes allowed |
| store_done_o | output | 1 | One-cycle pulse at the end of programming |

## Verification
All outputs are registered. A local trigger (`ext_store_i`, `pfail_i`) or a write request therefore shows up one edge after it is applied. A level on the shared line shows up three edges later because of the synchronizer. The pull-down stays active for STORE_CYCLES edges, and `store_done_o` appears on the edge where the pull-down ends. When the line returns high, `access_en_o` is restored three edges after that. The bench drives inputs and samples outputs on falling edges. It steps exactly the counted number of edges before each comparison and checks the value one edge earlier as well, so an early or late change is reported.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE         = 2'd0,
    ST_STORE_BUSY   = 2'd1,
    ST_WAIT_RELEASE = 2'd2
  } nvs_state_e;
endpackage

// File: rtl/nvs_sync.sv
// Multi-stage level synchronizer for an asynchronous input.
module nvs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= {STAGES{RST_VAL}};
    else     shreg <= {shreg[STAGES-2:0], d_i};
  end

  assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/nvs_dirty.sv
// Tracks whether the SRAM holds data newer than the shadow copy.
module nvs_dirty (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);
  always_ff @(posedge clk) begin
    if (rst)        dirty_o <= 1'b0;
    else if (set_i) dirty_o <= 1'b1;   // a newer write outranks a clear
    else if (clr_i) dirty_o <= 1'b0;
  end
endmodule

// File: rtl/nvs_store_fsm.sv
// Store sequencer: request detection, programming delay, lockout until release.
module nvs_store_fsm
  import nvs_pkg::*;
#(
  parameter int STORE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic line_hi_i,
  input  logic pfail_i,
  input  logic vlow_i,
  input  logic ext_store_i,
  input  logic wr_req_i,
  input  logic dirty_i,
  output logic pull_o,
  output logic done_o,
  output logic access_en_o,
  output logic wr_en_o
);
  localparam int CNT_W = (STORE_CYCLES > 1) ? $clog2(STORE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STORE_CYCLES - 1);

  nvs_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic trigger;

  // A peer low is a request. A local power fail bypasses the low-voltage gate.
  assign trigger = pfail_i | (ext_store_i & ~vlow_i) | ~line_hi_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (trigger) begin
          if (dirty_i) begin
            state_d = ST_STORE_BUSY;
            cnt_d   = CNT_LAST;
          end else begin
            state_d = ST_WAIT_RELEASE;
          end
        end
      end
      ST_STORE_BUSY: begin
        if (cnt_q == '0) state_d = ST_WAIT_RELEASE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_WAIT_RELEASE: begin
        // The block's own pull-down must not be mistaken for a peer holding the line.
        if (line_hi_i && !pull_o) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      pull_o      <= 1'b0;
      done_o      <= 1'b0;
      access_en_o <= 1'b1;
      wr_en_o     <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      pull_o      <= (state_d == ST_STORE_BUSY) ||
                     ((state_d == ST_WAIT_RELEASE) && pfail_i);
      done_o      <= (state_q == ST_STORE_BUSY) && (cnt_q == '0);
      access_en_o <= (state_d == ST_IDLE);
      wr_en_o     <= wr_req_i && !vlow_i && (state_d == ST_IDLE);
    end
  end
endmodule

// File: rtl/nvsram_store_ctrl.sv
// Top: shared-line synchronizer, dirty tracking and store sequencing.
module nvsram_store_ctrl #(
  parameter int STORE_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n_i,
  input  logic pfail_i,
  input  logic vlow_i,
  input  logic ext_store_i,
  input  logic wr_req_i,
  input  logic recall_done_i,
  output logic req_pull_o,
  output logic wr_en_o,
  output logic access_en_o,
  output logic store_done_o
);
  logic line_hi;
  logic dirty;

  nvs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (req_n_i),
    .q_o (line_hi)
  );

  nvs_dirty u_dirty (
    .clk     (clk),
    .rst     (rst),
    .set_i   (wr_en_o),
    .clr_i   (store_done_o | recall_done_i),
    .dirty_o (dirty)
  );

  nvs_store_fsm #(.STORE_CYCLES(STORE_CYCLES)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .line_hi_i   (line_hi),
    .pfail_i     (pfail_i),
    .vlow_i      (vlow_i),
    .ext_store_i (ext_store_i),
    .wr_req_i    (wr_req_i),
    .dirty_i     (dirty),
    .pull_o      (req_pull_o),
    .done_o      (store_done_o),
    .access_en_o (access_en_o),
    .wr_en_o     (wr_en_o)
  );
endmodule

// File: rtl/nvs_chk.sv
// Checker bound onto the top module.
module nvs_chk (
  input logic clk,
  input logic rst,
  input logic pfail_i,
  input logic vlow_i,
  input logic wr_req_i,
  input logic req_pull_o,
  input logic wr_en_o,
  input logic access_en_o,
  input logic store_done_o
);
  // R4
  busy_locks_access_chk: assert property (@(posedge clk) disable iff (rst)
    req_pull_o |-> !access_en_o);
  // R4
  done_ends_pull_chk: assert property (@(posedge clk) disable iff (rst)
    store_done_o |-> $past(req_pull_o));
  // R4
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    store_done_o |=> !store_done_o);
  // R2
  wr_gated_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> ($past(wr_req_i) && !$past(vlow_i)));
  // R10
  no_wr_when_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !access_en_o |-> !wr_en_o);
  // R8
  pfail_holds_pull_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pfail_i) && pfail_i && $past(req_pull_o)) |-> req_pull_o);
endmodule

bind nvsram_store_ctrl nvs_chk u_nvs_chk (
  .clk          (clk),
  .rst          (rst),
  .pfail_i      (pfail_i),
  .vlow_i       (vlow_i),
  .wr_req_i     (wr_req_i),
  .req_pull_o   (req_pull_o),
  .wr_en_o      (wr_en_o),
  .access_en_o  (access_en_o),
  .store_done_o (store_done_o)
);

// File: tb/tb_nvsram_store_ctrl.sv
module tb_nvsram_store_ctrl;
  localparam int S = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic peer_pull = 1'b0;
  logic pfail = 1'b0, vlow = 1'b0, ext_store = 1'b0, wr_req = 1'b0, recall_done = 1'b0;
  logic req_pull, wr_en, access_en, store_done;
  logic req_n;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // Open-drain line modelled as a wired AND with a pull-up.
  assign req_n = !(req_pull | peer_pull);

  nvsram_store_ctrl #(.STORE_CYCLES(S), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .req_n_i(req_n), .pfail_i(pfail), .vlow_i(vlow),
    .ext_store_i(ext_store), .wr_req_i(wr_req), .recall_done_i(recall_done),
    .req_pull_o(req_pull), .wr_en_o(wr_en), .access_en_o(access_en),
    .store_done_o(store_done)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // One write, which leaves the SRAM dirty.
  task automatic do_write();
    wr_req = 1'b1; step(1); wr_req = 1'b0;
    chk("R2 wr_en after request", wr_en, 1'b1);
    step(1);
    chk("R2 wr_en single cycle", wr_en, 1'b0);
  endtask

  // After the pull falls (in the cycle already sampled), expect the lockout to clear 3 edges later.
  task automatic expect_release(input string tag);
    step(2); chk({tag, " still locked"}, access_en, 1'b0);
    step(1); chk({tag, " access restored"}, access_en, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 pull", req_pull, 1'b0);
    chk("R1 wr_en", wr_en, 1'b0);
    chk("R1 done", store_done, 1'b0);
    chk("R1 access", access_en, 1'b1);
  endtask

  task automatic t_write_gate();
    vlow = 1'b1; wr_req = 1'b1; step(1); wr_req = 1'b0;
    chk("R2 write blocked by vlow", wr_en, 1'b0);
    vlow = 1'b0; step(1);
    do_write();
  endtask

  task automatic t_dirty_store();
    ext_store = 1'b1; step(1); ext_store = 1'b0;
    chk("R4 pull rises", req_pull, 1'b1);
    chk("R7 access drops", access_en, 1'b0);
    wr_req = 1'b1;
    step(S - 1);
    chk("R10 no write while locked", wr_en, 1'b0);
    chk("R4 pull held", req_pull, 1'b1);
    chk("R4 no early done", store_done, 1'b0);
    step(1); wr_req = 1'b0;
    chk("R4 pull falls", req_pull, 1'b0);
    chk("R4 done pulse", store_done, 1'b1);
    step(1);
    chk("R4 done one cycle", store_done, 1'b0);
    step(1); chk("R7 still locked", access_en, 1'b0);
    step(1); chk("R7 access restored", access_en, 1'b1);
  endtask

  task automatic t_clean_store(input string tag);
    ext_store = 1'b1; step(1); ext_store = 1'b0;
    chk({tag, " no pull"}, req_pull, 1'b0);
    chk("R5 access drops", access_en, 1'b0);
    step(1);
    chk({tag, " no done"}, store_done, 1'b0);
    chk("R5 access back", access_en, 1'b1);
  endtask

  task automatic t_vlow_store();
    do_write();
    vlow = 1'b1; ext_store = 1'b1; step(1); ext_store = 1'b0;
    chk("R3 no pull", req_pull, 1'b0);
    chk("R3 access kept", access_en, 1'b1);
    vlow = 1'b0; step(1);
    ext_store = 1'b1; step(1); ext_store = 1'b0;
    chk("R3 dirty kept, store runs", req_pull, 1'b1);
    step(S);
    chk("R3 done", store_done, 1'b1);
    expect_release("R7");
  endtask

  task automatic t_peer_dirty();
    do_write();
    peer_pull = 1'b1;
    step(2);
    chk("R6 not yet seen", access_en, 1'b1);
    step(1);
    chk("R6 peer request stores", req_pull, 1'b1);
    peer_pull = 1'b0;
    step(S - 1);
    chk("R6 pull held", req_pull, 1'b1);
    step(1);
    chk("R6 done", store_done, 1'b1);
    expect_release("R7 peer");
  endtask

  task automatic t_peer_clean();
    peer_pull = 1'b1;
    step(3);
    chk("R5 peer clean no pull", req_pull, 1'b0);
    chk("R7 peer clean locked", access_en, 1'b0);
    step(5);
    chk("R7 held while peer low", access_en, 1'b0);
    peer_pull = 1'b0;
    step(2); chk("R7 clean still locked", access_en, 1'b0);
    step(1); chk("R7 clean access restored", access_en, 1'b1);
  endtask

  task automatic t_pfail();
    do_write();
    vlow = 1'b1; pfail = 1'b1; step(1);
    chk("R8 pfail starts store under vlow", req_pull, 1'b1);
    step(S);
    chk("R8 done", store_done, 1'b1);
    chk("R8 pull held by pfail", req_pull, 1'b1);
    step(3);
    chk("R8 still pulled", req_pull, 1'b1);
    chk("R8 still locked", access_en, 1'b0);
    pfail = 1'b0; step(1);
    chk("R8 pull released", req_pull, 1'b0);
    expect_release("R8");
    vlow = 1'b0; step(1);
  endtask

  task automatic t_recall();
    do_write();
    recall_done = 1'b1; step(1); recall_done = 1'b0;
    step(1);
    t_clean_store("R9 after recall");
  endtask

  initial begin
    step(3); rst = 1'b0; step(1);
    t_reset();
    t_write_gate();
    t_dirty_store();
    t_clean_store("R9 after store");
    t_vlow_store();
    t_peer_dirty();
    t_peer_clean();
    t_pfail();
    t_recall();
    step(2);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule